// File: doc/BRIEF.md
# Run-Length Image Expander for a Video Processor Port

This block unpacks a compressed screen plane and writes it into the memory of a video display processor. The processor has two byte-wide write ports: a control port, which takes address setup bytes, and a data port, which takes bytes for consecutive memory locations. A pulse on `start` first sends the two-byte address setup to the control port, with the write-mode flag set. The block then decodes its byte input and sends every decoded byte to the data port. It stops when one full plane has been written.

The compressed form uses an escape byte. The value FFh never appears as a literal image byte, so FFh marks a repeat triple: FFh, then the byte to repeat, then the repeat count. Every other input byte is a literal and goes to the output unchanged. The pixel-pattern plane and the colour plane are compressed separately. Each one is started on its own, and `plane_sel` chooses which of two parameterised memory base addresses the setup sequence sends.

The input uses a valid/ready handshake. Each output strobe is held until the processor side raises `vdp_ready`. A strobe transfers on a rising clock edge where both the strobe and `vdp_ready` are high.

Top module: `rle_vdp_writer`

## Requirements
- R1: After reset the block is idle: both write strobes are low, `in_ready`, `busy`, `done` and `err` are low, and no byte is taken until `start` is pulsed.
- R2: `start` while idle, done or in error begins a plane with two control-port writes. The first carries base[7:0] and the second carries {2'b01, base[13:8]}, so bit 6 is set and bit 7 is clear. Base is `BMP_BASE` when `plane_sel` is 0 and `COL_BASE` when it is 1.
- R3: In stream, an input byte other than FFh is written once to the data port, unchanged.
- R4: The input triple FFh, v, n with n from 1 to 255 writes n consecutive data-port bytes of value v, in place of the three input bytes.
- R5: While `vdp_ready` is low, a raised strobe and its byte hold their values, and no input byte that would produce output is consumed.
- R6: `done` rises on the cycle after the `PLANE_BYTES`-th data write of a plane (6144 by default). A run that crosses that limit is cut at the limit.
- R7: While `done` is high, `in_ready` is high, incoming bytes are consumed and discarded, and no strobe is raised.
- R8: A repeat count of 0 writes nothing for that triple and raises `err` on the next cycle. From then until the next `start`, `in_ready` stays low and no strobe is raised.
- R9: `start` is ignored while `busy` is high, that is, during the setup writes or the stream.
- R10: The control strobe and the data strobe are never high together, and no data write occurs before both setup writes have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a plane (one-cycle pulse) |
| plane_sel | input | 1 | 0 selects the pattern-plane base, 1 the colour-plane base |
| in_data | input | 8 | Compressed input byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken on this edge when in_valid is high |
| vdp_data | output | 8 | Byte for the control or data port |
| vdp_ctrl_we | output | 1 | Write strobe for the control port |
| vdp_data_we | output | 1 | Write strobe for the data port |
| vdp_ready | input | 1 | Processor side accepts the raised strobe |
| busy | output | 1 | Setup or stream in progress |
| done | output | 1 | Plane complete |
| err | output | 1 | Zero repeat count seen |

## Verification
A fault in the internal run counter would show up straight away at the data port as a run that is too short or too long. Every later byte of the plane would then be out of place, and `done` would rise at the wrong time. A parser left in the wrong state would turn an escape, value or count byte into a literal. That error would be caught at the very next data write. A fault in the setup sequencer would show up in the first two control writes, before any data appears. A plane counter that is off by one would show as a missing or extra write at the plane boundary, or as a late `done`. The scoreboard compares every transfer in order as it happens, so each of these faults is reported at the cycle of the first wrong transfer.

// File: rtl/rlev_pkg.sv
package rlev_pkg;

  localparam int VRAM_AW = 14;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STREAM,
    PH_DONE,
    PH_ERR
  } phase_t;

  typedef enum logic [1:0] {
    PS_LIT,
    PS_VAL,
    PS_CNT,
    PS_RUN
  } parse_t;

  typedef enum logic [1:0] {
    SU_IDLE,
    SU_LO,
    SU_HI
  } setup_t;

  function automatic logic [7:0] addr_lo_byte(input logic [VRAM_AW-1:0] a);
    return a[7:0];
  endfunction

  function automatic logic [7:0] addr_hi_write(input logic [VRAM_AW-1:0] a);
    return {2'b01, a[VRAM_AW-1:8]};
  endfunction

endpackage

// File: rtl/rlev_setup.sv
module rlev_setup
  import rlev_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [VRAM_AW-1:0] base,
  input  logic               ready,
  output logic               ctrl_we,
  output logic [7:0]         ctrl_byte,
  output logic               is_hi,
  output logic               fin
);

  setup_t              st;
  logic [VRAM_AW-1:0]  base_q;

  assign ctrl_we   = (st != SU_IDLE);
  assign is_hi     = (st == SU_HI);
  assign ctrl_byte = is_hi ? addr_hi_write(base_q) : addr_lo_byte(base_q);
  assign fin       = is_hi && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SU_IDLE;
      base_q <= '0;
    end else begin
      case (st)
        SU_IDLE: if (go) begin
          base_q <= base;
          st     <= SU_LO;
        end
        SU_LO:   if (ready) st <= SU_HI;
        SU_HI:   if (ready) st <= SU_IDLE;
        default: st <= SU_IDLE;
      endcase
    end
  end

  // R2: the high address byte always follows an accepted low byte
  a_r2_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SU_LO && ready) |=> (st == SU_HI));

  // R5: a control byte held by the processor side keeps its value
  a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ready) |=> (ctrl_we && $stable(ctrl_byte)));

endmodule

// File: rtl/rlev_parse.sv
module rlev_parse
  import rlev_pkg::*;
#(
  parameter logic [7:0] ESC = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       en,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       run_active,
  output logic       zero_cnt
);

  parse_t     ps;
  logic [7:0] run_val;
  logic [7:0] run_left;
  logic       take;
  logic       is_esc;

  assign is_esc     = (in_data == ESC);
  assign run_active = (ps == PS_RUN);

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    case (ps)
      PS_LIT: begin
        out_valid = en && in_valid && !is_esc;
        in_ready  = en && (is_esc || out_ready);
      end
      PS_VAL, PS_CNT: in_ready = en;
      PS_RUN: begin
        out_valid = en;
        out_data  = run_val;
      end
      default: ;
    endcase
  end

  assign take     = in_valid && in_ready;
  assign zero_cnt = (ps == PS_CNT) && take && (in_data == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps       <= PS_LIT;
      run_val  <= '0;
      run_left <= '0;
    end else if (flush) begin
      ps <= PS_LIT;
    end else begin
      case (ps)
        PS_LIT: if (take && is_esc) ps <= PS_VAL;
        PS_VAL: if (take) begin
          run_val <= in_data;
          ps      <= PS_CNT;
        end
        PS_CNT: if (take) begin
          run_left <= in_data;
          ps       <= (in_data == 8'd0) ? PS_LIT : PS_RUN;
        end
        PS_RUN: if (en && out_ready) begin
          run_left <= run_left - 8'd1;
          if (run_left == 8'd1) ps <= PS_LIT;
        end
        default: ps <= PS_LIT;
      endcase
    end
  end

  // R5: a stalled run byte stays presented with the same value
  a_r5_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  // R4: an active run never has a zero remaining count
  a_r4_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_active |-> (run_left != 8'd0));

  // R3: the escape value itself is never sent out as a literal
  a_r3_no_esc_literal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !run_active) |-> (out_data != ESC));

endmodule

// File: rtl/rlev_count.sv
module rlev_count #(
  parameter int LIMIT = 6144,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fire,
  output logic [CW-1:0] cnt,
  output logic          last
);

  assign last = fire && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (fire) cnt <= cnt + CW'(1);
  end

  // R6: the plane counter never passes the plane size
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));

endmodule

// File: rtl/rle_vdp_writer.sv
module rle_vdp_writer
  import rlev_pkg::*;
#(
  parameter int                 PLANE_BYTES = 6144,
  parameter logic [VRAM_AW-1:0] BMP_BASE    = 14'h0000,
  parameter logic [VRAM_AW-1:0] COL_BASE    = 14'h2000,
  parameter logic [7:0]         ESC_BYTE    = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       plane_sel,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] vdp_data,
  output logic       vdp_ctrl_we,
  output logic       vdp_data_we,
  input  logic       vdp_ready,
  output logic       busy,
  output logic       done,
  output logic       err
);

  localparam int CW = $clog2(PLANE_BYTES + 1);

  phase_t             phase;
  logic               start_ok;
  logic [VRAM_AW-1:0] sel_base;
  logic               su_we, su_hi, su_fin;
  logic [7:0]         su_byte;
  logic               pr_en, pr_in_ready, pr_valid, pr_run, zero_cnt;
  logic [7:0]         pr_byte;
  logic               wr_fire, cnt_last;
  logic [CW-1:0]      out_cnt;

  assign busy     = (phase == PH_SETUP) || (phase == PH_STREAM);
  assign done     = (phase == PH_DONE);
  assign err      = (phase == PH_ERR);
  assign start_ok = start && !busy;
  assign sel_base = plane_sel ? COL_BASE : BMP_BASE;
  assign pr_en    = (phase == PH_STREAM);

  rlev_setup u_setup (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (start_ok),
    .base     (sel_base),
    .ready    (vdp_ready),
    .ctrl_we  (su_we),
    .ctrl_byte(su_byte),
    .is_hi    (su_hi),
    .fin      (su_fin)
  );

  rlev_parse #(.ESC(ESC_BYTE)) u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start_ok),
    .en        (pr_en),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (pr_in_ready),
    .out_data  (pr_byte),
    .out_valid (pr_valid),
    .out_ready (vdp_ready),
    .run_active(pr_run),
    .zero_cnt  (zero_cnt)
  );

  assign vdp_ctrl_we = su_we;
  assign vdp_data_we = pr_valid;
  assign vdp_data    = su_we ? su_byte : pr_byte;
  assign in_ready    = done || pr_in_ready;
  assign wr_fire     = vdp_data_we && vdp_ready;

  rlev_count #(.LIMIT(PLANE_BYTES)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_ok),
    .fire (wr_fire),
    .cnt  (out_cnt),
    .last (cnt_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE, PH_DONE, PH_ERR: if (start_ok) phase <= PH_SETUP;
        PH_SETUP:  if (su_fin) phase <= PH_STREAM;
        PH_STREAM: begin
          if (cnt_last)      phase <= PH_DONE;
          else if (zero_cnt) phase <= PH_ERR;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10: the two port strobes never overlap
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(vdp_ctrl_we && vdp_data_we));

  // R10: data writes only once setup has finished
  a_r10_data_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    vdp_data_we |-> (phase == PH_STREAM));

  // R2: the high setup byte selects write mode
  a_r2_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (vdp_ctrl_we && su_hi) |-> (vdp_data[6] && !vdp_data[7]));

  // R6: done follows the final plane write
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_last |=> done);

  // R7: nothing is written while done
  a_r7_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vdp_data_we && !vdp_ctrl_we && in_ready));

  // R8: zero count leads to error with no output and no intake
  a_r8_zero_err: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt |=> (err && !vdp_data_we && !in_ready));

  // R9: a start during the stream does not restart setup
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STREAM && start && !cnt_last && !zero_cnt) |=> (phase == PH_STREAM));

  // R5: a stalled run byte keeps its strobe
  a_r5_run_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_run && vdp_data_we && !vdp_ready) |=> vdp_data_we);

endmodule

// File: tb/rle_vdp_writer_tb.sv
module rle_vdp_writer_tb;

  localparam int          NB   = 6144;
  localparam logic [13:0] BMPB = 14'h0A5C;
  localparam logic [13:0] COLB = 14'h2B07;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       plane_sel = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] vdp_data;
  logic       vdp_ctrl_we, vdp_data_we;
  logic       vdp_ready = 1'b1;
  logic       busy, done, err;

  always #4 clk = ~clk;

  rle_vdp_writer #(.PLANE_BYTES(NB), .BMP_BASE(BMPB), .COL_BASE(COLB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .plane_sel(plane_sel),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .vdp_data(vdp_data), .vdp_ctrl_we(vdp_ctrl_we), .vdp_data_we(vdp_data_we),
    .vdp_ready(vdp_ready), .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] exp_q[$];
  logic [7:0] in_q[$];
  int remaining = 0;
  logic stall_mode = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // processor-side readiness: always ready, or a pseudo-random stall pattern
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    vdp_ready <= stall_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  // monitor: compare each transfer with the scoreboard queue
  logic       prev_stall = 1'b0;
  logic [7:0] prev_byte = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (vdp_ctrl_we && vdp_data_we)
        check(1'b0, "R10 strobe overlap", 1, 0);
      if (prev_stall)
        check(vdp_data_we && vdp_data == prev_byte, "R5 stall hold", vdp_data, prev_byte);
      prev_stall = vdp_data_we && !vdp_ready;
      prev_byte  = vdp_data;
      if ((vdp_ctrl_we || vdp_data_we) && vdp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7/R8/R9 unexpected write", {vdp_ctrl_we, vdp_data}, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({vdp_ctrl_we, vdp_data} == e,
                e[8] ? "R2 ctrl byte" : "R3/R4/R6 data byte",
                {vdp_ctrl_we, vdp_data}, e);
        end
      end
    end
  end

  // expectation builders (from the requirements)
  task automatic add_lit(input logic [7:0] b);
    in_q.push_back(b);
    if (remaining > 0) begin
      exp_q.push_back({1'b0, b});
      remaining--;
    end
  endtask

  task automatic add_run(input logic [7:0] v, input int n);
    in_q.push_back(8'hFF);
    in_q.push_back(v);
    in_q.push_back(n[7:0]);
    for (int k = 0; k < n; k++) begin
      if (remaining > 0) begin
        exp_q.push_back({1'b0, v});
        remaining--;
      end
    end
  endtask

  task automatic begin_plane(input logic sel);
    logic [13:0] b;
    b = sel ? COLB : BMPB;
    remaining = NB;
    exp_q.push_back({1'b1, b[7:0]});
    exp_q.push_back({1'b1, 8'(b >> 8) + 8'd64});
    @(posedge clk); #1;
    start = 1'b1; plane_sel = sel;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic gen_plane(input int seed, input bit exact);
    int i = 0;
    add_run(8'h00, 3);
    add_run(8'hFE, 255);
    add_lit(8'h00);
    add_lit(8'hFE);
    while (remaining > 0) begin
      if ((i % 3) == 2 && remaining >= 3) begin
        int n;
        n = ((i * 37 + seed) % 253) + 3;
        if (exact && n > remaining) n = remaining;
        add_run(8'((i * 11 + seed) % 255), n);
      end else begin
        add_lit(8'((i * 5 + seed) % 255));
      end
      i++;
    end
  endtask

  task automatic drive_all();
    while (in_q.size() > 0) begin
      in_data  = in_q.pop_front();
      in_valid = 1'b1;
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic wait_drain(input string tag);
    int t = 0;
    while ((exp_q.size() > 0) && t < 40000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!vdp_ctrl_we && !vdp_data_we, "R1 strobes in reset", {vdp_ctrl_we, vdp_data_we}, 0);
    check(!in_ready && !busy && !done && !err, "R1 flags in reset", {in_ready, busy, done, err}, 0);
    rst_n = 1'b1;
    in_valid = 1'b1; in_data = 8'h33;
    repeat (4) @(negedge clk);
    check(!in_ready && !busy, "R1 idle without start", {in_ready, busy}, 0);
    @(posedge clk); #1; in_valid = 1'b0;

    // plane A: pattern plane, no stalls
    begin_plane(1'b0);
    gen_plane(7, 1'b1);
    drive_all();
    wait_drain("R6 plane A drained");
    check(done && !err && !busy, "R6 done plane A", {done, err, busy}, 4);

    // plane B: colour plane with stalls and an ignored start mid-stream
    stall_mode = 1'b1;
    begin_plane(1'b1);
    gen_plane(91, 1'b1);
    fork
      drive_all();
      begin
        repeat (400) @(posedge clk);
        #1;
        check(busy, "R9 busy before late start", busy, 1);
        start = 1'b1; plane_sel = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
      end
    join
    wait_drain("R9 plane B drained");
    check(done && !err, "R6 done plane B", {done, err}, 2);

    // plane C: run crossing the limit plus trailing bytes
    begin_plane(1'b0);
    gen_plane(200, 1'b0);
    add_lit(8'h12);
    add_run(8'h44, 9);
    add_lit(8'h56);
    drive_all();
    wait_drain("R6 plane C drained");
    check(done, "R6 done after truncated run", done, 1);
    check(in_ready, "R7 input taken while done", in_ready, 1);

    // plane D: zero count error
    stall_mode = 1'b0;
    begin_plane(1'b1);
    remaining = 3;
    add_lit(8'h01); add_lit(8'h02); add_lit(8'h03);
    in_q.push_back(8'hFF); in_q.push_back(8'h12); in_q.push_back(8'h00);
    drive_all();
    @(negedge clk);
    check(err && !done && !busy, "R8 err after zero count", {err, done, busy}, 4);
    in_valid = 1'b1; in_data = 8'h77;
    repeat (8) begin
      @(negedge clk);
      check(!in_ready, "R8 input held off in error", in_ready, 0);
    end
    @(posedge clk); #1; in_valid = 1'b0;
    wait_drain("R8 no output from error triple");

    // plane E: restart after error
    begin_plane(1'b0);
    @(negedge clk);
    check(!err && busy, "R2 restart clears error", {err, busy}, 1);
    gen_plane(33, 1'b1);
    drive_all();
    wait_drain("R6 plane E drained");
    check(done && !err, "R6 done plane E", {done, err}, 2);

    summary();
    $finish;
  end

endmodule